// File: doc/BRIEF.md
# Phase-Stepped SD Card Clock Generator

This block derives three related clocks for an SD host controller from one fast source, modelled here as a one-cycle tick input: a transmit clock for the controller's output registers, a card clock sent to the card, and a receive sampling clock. Each source tick advances a phase counter by one step. A base period is a selectable number of steps, and an optional divider stretches the output period to a whole number of base periods. The card clock is the transmit clock shifted later by a programmed number of steps. The receive clock takes the same shifted phase, so sampling lines up with the card clock.

Software programs the block through a small word-addressed register port. The divide ratio, the divider-mode bit and the two clock enables can each come from the host controller's own pins or from a locally programmed register. A separate select register chooses the source for each field independently. A soft-reset bit starts set and stops all three clocks while the block is configured. Read-only status bits report which clocks have completed a cycle. A new configuration is loaded only at an output-cycle boundary, so the card never sees a shortened pulse.

Top module: `sdclk_phase_gen`

Register map (word index on `reg_addr`, 1 = local value in the select register):
- 0 control: bit 0 soft reset (writable, resets to 1); read-only bit 8 transmit running, bit 12 card running, bit 16 receive running.
- 1 mode: bits 1:0 source (0 stopped, 1 alternate, 2 or 3 main); bits 6:4 steps code.
- 2 local values: bits 9:0 divide select, bit 16 divider mode, bit 17 transmit enable, bit 18 card enable.
- 3 select: bit 0 divide select, bit 1 divider mode, bit 2 transmit enable, bit 3 card enable.
- 4 card delay: bits 4:0, steps; resets to 5.

## Requirements
- R1: After reset the control word reads 1, the mode word reads 0, the delay word reads 5, and all three clock outputs are low.
- R2: The mode steps code sets the steps per base period: 0→20, 1→10, 2→16, 3→8, 4→12, 5→6, 6→5, 7→4.
- R3: In divided mode (divider-mode bit 1) the output period is steps×(divide select+1) ticks, and the transmit clock is high for the first floor(period/2) ticks of it.
- R4: In programmable mode (divider-mode bit 0) the divide select is ignored and the period is one base period of steps ticks.
- R5: The card clock rises a number of ticks after the transmit clock equal to the delay word, limited to steps−1.
- R6: While soft reset is 1 or the source is 0, all three outputs are low and the status bits read 0 from the next cycle on.
- R7: After release, a running bit is set only when the first full output cycle ends. It then reports whether that clock was enabled in the cycle that just ended.
- R8: With the transmit enable 1 and the card enable 0, the transmit and receive clocks run and their status bits read 1, while the card clock stays low and its status bit reads 0.
- R9: For each of the four control fields, a select bit of 0 takes the host pin and 1 takes the local register.
- R10: A configuration change written mid-cycle leaves the current output cycle at its old length and applies from the next cycle on.
- R11: Only control bit 0 is writable; writing ones to any other control bit leaves the status bits unchanged.
- R12: The phase counter advances only in cycles with `src_tick` high, so ticks every other clock double the period in clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | One phase step per high cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| host_freq_sel | input | 10 | Host-supplied divide select |
| host_div_mode | input | 1 | Host-supplied divider-mode bit |
| host_tx_en | input | 1 | Host-supplied transmit enable |
| host_card_on | input | 1 | Host-supplied card enable |
| tx_clk_o | output | 1 | Transmit clock |
| card_clk_o | output | 1 | Card clock |
| rx_clk_o | output | 1 | Receive sampling clock |

## Verification
The assertions assume that `src_tick` and the host pins are sampled on the block clock and that register writes arrive as single-cycle strobes. They also assume that no one counts on a new configuration before the next cycle boundary. The bench drives every input at the falling edge and holds each write for one cycle. It changes host pins or modes only while the clocks run, so changes land at a boundary, and it measures periods only after several further rising edges. Tick gaps are applied as a regular every-other-cycle pattern.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  localparam int STEP_W = 5;

  typedef enum logic [2:0] {
    ADR_CTRL   = 3'd0,
    ADR_MODE   = 3'd1,
    ADR_LOCAL  = 3'd2,
    ADR_SELECT = 3'd3,
    ADR_DELAY  = 3'd4
  } reg_addr_e;

  localparam int CTRL_TX_RUN_BIT = 8;
  localparam int CTRL_SD_RUN_BIT = 12;
  localparam int CTRL_RX_RUN_BIT = 16;
  localparam int LOC_GEN_BIT     = 16;
  localparam int LOC_TX_BIT      = 17;
  localparam int LOC_CARD_BIT    = 18;

  typedef struct packed {
    logic div_mode;
    logic tx_en;
    logic card_on;
  } ctl_bits_t;

  // Steps per base period for each 3-bit code.
  function automatic logic [STEP_W-1:0] steps_of(input logic [2:0] code);
    logic [STEP_W-1:0] n;
    case (code)
      3'd0:    n = 5'd20;
      3'd1:    n = 5'd10;
      3'd2:    n = 5'd16;
      3'd3:    n = 5'd8;
      3'd4:    n = 5'd12;
      3'd5:    n = 5'd6;
      3'd6:    n = 5'd5;
      default: n = 5'd4;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int FREQ_W    = 10,
  parameter int DLY_W     = 5,
  parameter int DLY_RESET = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [FREQ_W-1:0] host_freq,
  input  ctl_bits_t         host_bits,
  input  logic              tx_run,
  input  logic              sd_run,
  input  logic              rx_run,
  output logic              soft_rst,
  output logic [1:0]        src_sel,
  output logic [2:0]        steps_code,
  output logic [FREQ_W-1:0] eff_freq,
  output ctl_bits_t         eff_bits,
  output logic [DLY_W-1:0]  dly
);

  logic              soft_rst_q, soft_rst_d;
  logic [1:0]        src_q, src_d;
  logic [2:0]        code_q, code_d;
  logic [FREQ_W-1:0] loc_freq_q, loc_freq_d;
  ctl_bits_t         loc_bits_q, loc_bits_d;
  logic [3:0]        sel_q, sel_d;
  logic [DLY_W-1:0]  dly_q, dly_d;

  always_comb begin
    soft_rst_d = soft_rst_q;
    src_d      = src_q;
    code_d     = code_q;
    loc_freq_d = loc_freq_q;
    loc_bits_d = loc_bits_q;
    sel_d      = sel_q;
    dly_d      = dly_q;
    if (wr_en) begin
      case (reg_addr_e'(addr))
        ADR_CTRL:   soft_rst_d = wdata[0];
        ADR_MODE: begin
          src_d  = wdata[1:0];
          code_d = wdata[6:4];
        end
        ADR_LOCAL: begin
          loc_freq_d          = wdata[FREQ_W-1:0];
          loc_bits_d.div_mode = wdata[LOC_GEN_BIT];
          loc_bits_d.tx_en    = wdata[LOC_TX_BIT];
          loc_bits_d.card_on  = wdata[LOC_CARD_BIT];
        end
        ADR_SELECT: sel_d = wdata[3:0];
        ADR_DELAY:  dly_d = wdata[DLY_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst_q <= 1'b1;
      src_q      <= '0;
      code_q     <= '0;
      loc_freq_q <= '0;
      loc_bits_q <= '0;
      sel_q      <= '0;
      dly_q      <= DLY_W'(DLY_RESET);
    end else begin
      soft_rst_q <= soft_rst_d;
      src_q      <= src_d;
      code_q     <= code_d;
      loc_freq_q <= loc_freq_d;
      loc_bits_q <= loc_bits_d;
      sel_q      <= sel_d;
      dly_q      <= dly_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      ADR_CTRL: begin
        rdata[0]               = soft_rst_q;
        rdata[CTRL_TX_RUN_BIT] = tx_run;
        rdata[CTRL_SD_RUN_BIT] = sd_run;
        rdata[CTRL_RX_RUN_BIT] = rx_run;
      end
      ADR_MODE: begin
        rdata[1:0] = src_q;
        rdata[6:4] = code_q;
      end
      ADR_LOCAL: begin
        rdata[FREQ_W-1:0]   = loc_freq_q;
        rdata[LOC_GEN_BIT]  = loc_bits_q.div_mode;
        rdata[LOC_TX_BIT]   = loc_bits_q.tx_en;
        rdata[LOC_CARD_BIT] = loc_bits_q.card_on;
      end
      ADR_SELECT: rdata[3:0]       = sel_q;
      ADR_DELAY:  rdata[DLY_W-1:0] = dly_q;
      default: ;
    endcase
  end

  // Field-by-field choice between host pin and local register.
  assign eff_freq          = sel_q[0] ? loc_freq_q          : host_freq;
  assign eff_bits.div_mode = sel_q[1] ? loc_bits_q.div_mode : host_bits.div_mode;
  assign eff_bits.tx_en    = sel_q[2] ? loc_bits_q.tx_en    : host_bits.tx_en;
  assign eff_bits.card_on  = sel_q[3] ? loc_bits_q.card_on  : host_bits.card_on;

  assign soft_rst   = soft_rst_q;
  assign src_sel    = src_q;
  assign steps_code = code_q;
  assign dly        = dly_q;

endmodule

// File: rtl/sdclk_phase.sv
module sdclk_phase
  import sdclk_pkg::*;
#(
  parameter int FREQ_W = 10,
  parameter int DLY_W  = 5,
  parameter int CNT_W  = STEP_W + FREQ_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [STEP_W-1:0] steps,
  input  logic [FREQ_W-1:0] freq,
  input  ctl_bits_t         bits_in,
  input  logic [DLY_W-1:0]  dly,
  output logic              tx_clk,
  output logic              card_clk,
  output logic              rx_clk,
  output logic              wrap,
  output logic              cur_tx_en,
  output logic              cur_card_on
);

  logic [CNT_W-1:0] pos_q, pos_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic [CNT_W-1:0] dly_q, dly_d;
  logic             tx_en_q, tx_en_d;
  logic             card_q, card_d;

  logic [FREQ_W:0]  ratio;
  logic [CNT_W-1:0] new_len;
  logic [CNT_W-1:0] new_dly;
  logic [CNT_W-1:0] step_lim;
  logic             last;
  logic             load;
  logic [CNT_W-1:0] shifted;

  // Candidate configuration for the next output cycle.
  always_comb begin
    ratio    = bits_in.div_mode ? ({1'b0, freq} + (FREQ_W+1)'(1)) : (FREQ_W+1)'(1);
    new_len  = CNT_W'(steps) * CNT_W'(ratio);
    step_lim = CNT_W'(steps) - CNT_W'(1);
    new_dly  = (CNT_W'(dly) > step_lim) ? step_lim : CNT_W'(dly);
  end

  assign last = (pos_q == len_q - CNT_W'(1));
  assign wrap = run & tick & last;
  assign load = !run || wrap;

  always_comb begin
    pos_d   = pos_q;
    len_d   = len_q;
    half_d  = half_q;
    dly_d   = dly_q;
    tx_en_d = tx_en_q;
    card_d  = card_q;
    if (!run) begin
      pos_d = '0;
    end else if (tick) begin
      pos_d = last ? '0 : pos_q + CNT_W'(1);
    end
    if (load) begin
      len_d   = new_len;
      half_d  = new_len >> 1;
      dly_d   = new_dly;
      tx_en_d = bits_in.tx_en;
      card_d  = bits_in.card_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      len_q   <= CNT_W'(4);
      half_q  <= CNT_W'(2);
      dly_q   <= '0;
      tx_en_q <= 1'b0;
      card_q  <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      len_q   <= len_d;
      half_q  <= half_d;
      dly_q   <= dly_d;
      tx_en_q <= tx_en_d;
      card_q  <= card_d;
    end
  end

  // Card and receive phase: transmit phase moved later by the delay.
  assign shifted = (pos_q >= dly_q) ? (pos_q - dly_q) : (pos_q + len_q - dly_q);

  assign tx_clk      = run & tx_en_q & (pos_q < half_q);
  assign card_clk    = run & card_q  & (shifted < half_q);
  assign rx_clk      = run & tx_en_q & (shifted < half_q);
  assign cur_tx_en   = tx_en_q;
  assign cur_card_on = card_q;

endmodule

// File: rtl/sdclk_status.sv
module sdclk_status (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic wrap,
  input  logic cur_tx_en,
  input  logic cur_card_on,
  output logic tx_run,
  output logic sd_run,
  output logic rx_run
);

  logic tx_q, tx_d, sd_q, sd_d, rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    sd_d = sd_q;
    rx_d = rx_q;
    if (!run) begin
      tx_d = 1'b0;
      sd_d = 1'b0;
      rx_d = 1'b0;
    end else if (wrap) begin
      tx_d = cur_tx_en;
      sd_d = cur_card_on;
      rx_d = cur_tx_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b0;
      sd_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      tx_q <= tx_d;
      sd_q <= sd_d;
      rx_q <= rx_d;
    end
  end

  assign tx_run = tx_q;
  assign sd_run = sd_q;
  assign rx_run = rx_q;

endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen
  import sdclk_pkg::*;
#(
  parameter int FREQ_W    = 10,
  parameter int DLY_W     = 5,
  parameter int DLY_RESET = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [FREQ_W-1:0] host_freq_sel,
  input  logic              host_div_mode,
  input  logic              host_tx_en,
  input  logic              host_card_on,
  output logic              tx_clk_o,
  output logic              card_clk_o,
  output logic              rx_clk_o
);

  localparam int CNT_W = STEP_W + FREQ_W + 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              soft_rst;
  logic [1:0]        src_sel;
  logic [2:0]        steps_code;
  logic [FREQ_W-1:0] eff_freq;
  ctl_bits_t         eff_bits;
  ctl_bits_t         host_bits;
  logic [DLY_W-1:0]  dly;
  logic              run;
  logic              wrap;
  logic              cur_tx_en;
  logic              cur_card_on;
  logic              tx_run, sd_run, rx_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign host_bits.div_mode = host_div_mode;
  assign host_bits.tx_en    = host_tx_en;
  assign host_bits.card_on  = host_card_on;

  sdclk_regs #(
    .FREQ_W(FREQ_W), .DLY_W(DLY_W), .DLY_RESET(DLY_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .host_freq(host_freq_sel), .host_bits(host_bits),
    .tx_run(tx_run), .sd_run(sd_run), .rx_run(rx_run),
    .soft_rst(soft_rst), .src_sel(src_sel), .steps_code(steps_code),
    .eff_freq(eff_freq), .eff_bits(eff_bits), .dly(dly)
  );

  assign run = !soft_rst && (src_sel != 2'd0);

  sdclk_phase #(
    .FREQ_W(FREQ_W), .DLY_W(DLY_W), .CNT_W(CNT_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_int_n), .run(run), .tick(src_tick),
    .steps(steps_of(steps_code)), .freq(eff_freq), .bits_in(eff_bits), .dly(dly),
    .tx_clk(tx_clk_o), .card_clk(card_clk_o), .rx_clk(rx_clk_o),
    .wrap(wrap), .cur_tx_en(cur_tx_en), .cur_card_on(cur_card_on)
  );

  sdclk_status u_status (
    .clk(clk), .rst_n(rst_int_n), .run(run), .wrap(wrap),
    .cur_tx_en(cur_tx_en), .cur_card_on(cur_card_on),
    .tx_run(tx_run), .sd_run(sd_run), .rx_run(rx_run)
  );

endmodule

// File: rtl/sdclk_phase_gen_chk.sv
module sdclk_phase_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic wrap,
  input logic src_tick,
  input logic tx_clk,
  input logic card_clk,
  input logic rx_clk,
  input logic tx_run,
  input logic sd_run,
  input logic rx_run
);

  p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!tx_clk && !card_clk && !rx_clk));

  p_flags_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!tx_run && !sd_run && !rx_run));

  p_flag_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_run) || $rose(sd_run) || $rose(rx_run)) |-> $past(wrap));

  p_tx_rise_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_clk) |-> ($past(wrap) || !$past(run)));

  p_hold_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(src_tick)) |->
      ($stable(tx_clk) && $stable(card_clk) && $stable(rx_clk)));

endmodule

bind sdclk_phase_gen sdclk_phase_gen_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .run(run), .wrap(wrap), .src_tick(src_tick),
  .tx_clk(tx_clk_o), .card_clk(card_clk_o), .rx_clk(rx_clk_o),
  .tx_run(tx_run), .sd_run(sd_run), .rx_run(rx_run)
);

// File: tb/sdclk_phase_gen_tb.sv
module sdclk_phase_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_tick = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [9:0]  host_freq_sel = '0;
  logic        host_div_mode = 1'b0;
  logic        host_tx_en = 1'b0;
  logic        host_card_on = 1'b0;
  logic        tx_clk_o, card_clk_o, rx_clk_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit tick_alt = 1'b0;

  always #5 clk = ~clk;

  sdclk_phase_gen dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_freq_sel(host_freq_sel),
    .host_div_mode(host_div_mode), .host_tx_en(host_tx_en),
    .host_card_on(host_card_on), .tx_clk_o(tx_clk_o),
    .card_clk_o(card_clk_o), .rx_clk_o(rx_clk_o)
  );

  // Edge monitor sampled at the falling edge.
  int  cyc = 0;
  int  tx_last_rise = 0, tx_period = 0, tx_high = 0, tx_rises = 0;
  int  card_last_rise = 0, card_rises = 0, card_hi_cnt = 0, tx_hi_cnt = 0;
  logic tx_prev = 1'b0, card_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (tx_clk_o && !tx_prev) begin
      tx_period = cyc - tx_last_rise;
      tx_last_rise = cyc;
      tx_rises++;
    end
    if (!tx_clk_o && tx_prev) tx_high = cyc - tx_last_rise;
    if (card_clk_o && !card_prev) begin
      card_last_rise = cyc;
      card_rises++;
    end
    if (card_clk_o) card_hi_cnt++;
    if (tx_clk_o) tx_hi_cnt++;
    tx_prev = tx_clk_o;
    card_prev = card_clk_o;
    src_tick = tick_alt ? ~src_tick : 1'b1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_tx_rises(input int n);
    int start = tx_rises;
    while (tx_rises < start + n) @(negedge clk);
  endtask

  task automatic card_offset(output int off);
    int start;
    wait_tx_rises(1);
    start = card_rises;
    while (card_rises == start) @(negedge clk);
    off = card_last_rise - tx_last_rise;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 ctrl after reset", int'(d), 1);
    rd(3'd1, d); chk("R1 mode after reset", int'(d), 0);
    rd(3'd4, d); chk("R1 delay after reset", int'(d), 5);
    chk("R1 outputs low", int'({tx_clk_o, card_clk_o, rx_clk_o}), 0);
  endtask

  task automatic t_release;
    logic [31:0] d;
    host_freq_sel = 10'd1; host_div_mode = 1'b1;
    host_tx_en = 1'b1; host_card_on = 1'b1;
    wr(3'd1, 32'h72);
    wr(3'd0, 32'h0);
    repeat (3) @(negedge clk);
    rd(3'd0, d); chk("R7 flags clear before first cycle end", int'(d), 0);
    repeat (8) @(negedge clk);
    rd(3'd0, d); chk("R7 flags set after first cycle", int'(d), 32'h11100);
  endtask

  task automatic t_divide;
    wait_tx_rises(3);
    chk("R3 period steps4 div2", tx_period, 8);
    chk("R3 high time div2", tx_high, 4);
    host_freq_sel = 10'd2;
    wait_tx_rises(3);
    chk("R3 period steps4 div3", tx_period, 12);
    chk("R3 high time div3", tx_high, 6);
    host_freq_sel = 10'd1;
    wait_tx_rises(3);
  endtask

  task automatic t_steps;
    wr(3'd1, 32'h52);
    wait_tx_rises(3);
    chk("R2 code5 six steps", tx_period, 12);
    wr(3'd1, 32'h02);
    wait_tx_rises(3);
    chk("R2 code0 twenty steps", tx_period, 40);
    wr(3'd1, 32'h72);
    wait_tx_rises(3);
    chk("R2 code7 four steps", tx_period, 8);
  endtask

  task automatic t_progmode;
    host_div_mode = 1'b0;
    wait_tx_rises(3);
    chk("R4 programmable mode ignores divide", tx_period, 4);
    host_div_mode = 1'b1;
    wait_tx_rises(3);
  endtask

  task automatic t_delay;
    int off;
    card_offset(off); chk("R5 delay 5 limited to 3", off, 3);
    wr(3'd4, 32'd2);
    wait_tx_rises(3);
    card_offset(off); chk("R5 delay 2", off, 2);
    wr(3'd4, 32'd1);
    wait_tx_rises(3);
    card_offset(off); chk("R5 delay 1", off, 1);
  endtask

  task automatic t_override;
    wr(3'd2, 32'h70003);
    wr(3'd3, 32'h1);
    wait_tx_rises(3);
    chk("R9 local divide select", tx_period, 16);
    host_tx_en = 1'b0;
    wr(3'd3, 32'h5);
    wait_tx_rises(3);
    chk("R9 local transmit enable", tx_period, 16);
    wr(3'd3, 32'h1);
    repeat (40) @(negedge clk);
    tx_hi_cnt = 0;
    repeat (40) @(negedge clk);
    chk("R9 host transmit enable low", tx_hi_cnt, 0);
    host_tx_en = 1'b1;
    wr(3'd3, 32'h0);
    wait_tx_rises(3);
    chk("R9 host divide select back", tx_period, 8);
  endtask

  task automatic t_boundary;
    wait_tx_rises(1);
    wr(3'd2, 32'h70007);
    wr(3'd3, 32'h1);
    wait_tx_rises(1);
    chk("R10 current cycle keeps old length", tx_period, 8);
    wait_tx_rises(1);
    chk("R10 new length from next cycle", tx_period, 32);
    wr(3'd3, 32'h0);
    wait_tx_rises(3);
  endtask

  task automatic t_tx_only;
    logic [31:0] d;
    wr(3'd2, 32'h30000);
    wr(3'd3, 32'hC);
    wait_tx_rises(4);
    card_hi_cnt = 0;
    repeat (24) @(negedge clk);
    chk("R8 card clock stays low", card_hi_cnt, 0);
    chk("R8 transmit period", tx_period, 8);
    rd(3'd0, d); chk("R8 flags tx and rx only", int'(d), 32'h10100);
    wr(3'd3, 32'h0);
    wait_tx_rises(3);
  endtask

  task automatic t_tick;
    tick_alt = 1'b1;
    wait_tx_rises(4);
    chk("R12 ticks every other clock", tx_period, 16);
    tick_alt = 1'b0;
    wait_tx_rises(3);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(3'd1, 32'h70);
    repeat (2) @(negedge clk);
    chk("R6 source stop outputs low", int'({tx_clk_o, card_clk_o, rx_clk_o}), 0);
    rd(3'd0, d); chk("R6 source stop flags", int'(d), 0);
    wr(3'd1, 32'h72);
    wait_tx_rises(3);
    wr(3'd0, 32'h1);
    tx_hi_cnt = 0; card_hi_cnt = 0;
    repeat (20) @(negedge clk);
    chk("R6 soft reset outputs low", tx_hi_cnt + card_hi_cnt + int'(rx_clk_o), 0);
    rd(3'd0, d); chk("R6 soft reset flags", int'(d), 1);
  endtask

  task automatic t_ctrl_ro;
    logic [31:0] d;
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R11 only reset bit writable", int'(d), 1);
    wr(3'd1, 32'h70);
    wr(3'd0, 32'hFFFF_FFFE);
    repeat (12) @(negedge clk);
    rd(3'd0, d); chk("R11 status bits not writable", int'(d), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_release();
    t_divide();
    t_steps();
    t_progmode();
    t_delay();
    t_override();
    t_boundary();
    t_tx_only();
    t_tick();
    t_stop();
    t_ctrl_ro();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule